// File: doc/BRIEF.md
# Serial Controller Register and Status Bank

This block is the byte-wide control and status register file of a FIFO-equipped asynchronous serial controller. Software reaches it through a small register bus: an address, a write strobe, a read strobe, write data, and read data that is returned one cycle later. The bank holds the mode, bit-rate, control, FIFO-control and port registers. Each register keeps only the bits its write mask allows. It also keeps five status flags: transmit-end, transmit-data-empty, break, receive-full and data-ready. Software clears a flag by writing zero to its bit.

The bank does not contain the shifter, the baud generator or the receive FIFO storage. Receive-side conditions arrive as single-cycle event pulses. The FIFO head byte and its fill level arrive as inputs, and a read of the receive data register returns a pop strobe. A write to the transmit data register leaves the block as a byte with a valid strobe. Two interrupt lines go out: a transmit line that follows a control bit, and a receive line that is raised by a receive-full event.

Top module: `serial_regs_top`

## Requirements
- R1: After reset, the registers read as follows: bit-rate 0xFF, control 0x20, mode 0x00, port 0x00, FIFO control 0x00, and status 0x60 (transmit-end and transmit-data-empty set). After reset, tx_irq and rx_irq are 0.
- R2: Writes are masked per register. Mode keeps only the bits in 0x7B, control keeps 0xFA, and port keeps 0xF3. Bit-rate and FIFO control keep all 8 bits. A read returns the value that was stored. Register offsets are: mode 0x00, bit-rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, receive count 0x1C, port 0x20, line status 0x24.
- R3: The status byte holds transmit-end in bit 6, transmit-data-empty in bit 5, break in bit 4, receive-full in bit 1 and data-ready in bit 0. All other bits read as 0. The pulses rx_ready_evt, rx_full_evt and rx_break_evt set data-ready, receive-full and break.
- R4: A status write clears each of the five flags whose bit is written as 0. A flag whose bit is written as 1 keeps its value.
- R5: A status read while control bit 5 (transmit enable) is 1 returns the flags as they were before the read. After the read, both transmit-end and transmit-data-empty are set.
- R6: A control write with bit 5 at 0 sets the transmit-end flag.
- R7: A write to offset 0x0C drives tx_valid high for exactly one cycle, in the cycle after the write, with tx_byte equal to the written byte. The same write clears transmit-data-empty.
- R8: After every control write, tx_irq equals bit 7 of the written byte.
- R9: rx_irq rises after an rx_full_evt pulse that arrives while control bit 6 is 1. It falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0.
- R10: An access to an offset outside the ten mapped offsets raises err for one cycle, returns 0 on a read, and changes no state. An access to a mapped offset never raises err.
- R11: If a flag's set event and a software clear of that flag occur in the same cycle, the flag ends up set. The same holds for rx_irq.
- R12: A read of offset 0x14 pulses rx_pop in the access cycle and returns rx_data. A read of offset 0x1C returns rx_level zero-extended. Offsets 0x24 and 0x0C read as 0. Writes to 0x14, 0x1C and 0x24 change nothing. When write and read are both asserted, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| tx_byte | output | 8 | Byte written to the transmit data register |
| tx_valid | output | 1 | One-cycle strobe qualifying tx_byte |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |
| rx_ready_evt | input | 1 | Pulse that sets data-ready |
| rx_full_evt | input | 1 | Pulse that sets receive-full |
| rx_break_evt | input | 1 | Pulse that sets break |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_level | input | 5 | Fill level of the receive FIFO |
| rx_pop | output | 1 | Pop strobe, high during a receive data read |
| fifo_ctrl | output | 8 | Current FIFO control register value |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 6-bit address, a 5-bit level and the 0x7B/0xFA/0xF3 masks. With a 6-bit address, every offset in the 64-byte window can be reached. This includes misaligned and out-of-range offsets, so the bank's unmapped-error path is exercised next to all ten mapped offsets. Random accesses are interleaved with random event pulses. This lets a set event land in the same cycle as a status write clear, and lets a status read occur with transmit enable both on and off.

// File: rtl/serial_regs_pkg.sv
// Shared constants and types for the serial register bank.
// Assumes byte offsets inside a 64-byte window and an 8-bit data path.
package serial_regs_pkg;

    // Register offsets within the bank
    localparam int OFF_MODE  = 'h00;
    localparam int OFF_BAUD  = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_TXD   = 'h0C;
    localparam int OFF_STAT  = 'h10;
    localparam int OFF_RXD   = 'h14;
    localparam int OFF_FCTL  = 'h18;
    localparam int OFF_RCNT  = 'h1C;
    localparam int OFF_PORT  = 'h20;
    localparam int OFF_LSTAT = 'h24;

    // Register select produced by the decoder
    typedef enum logic [3:0] {
        SEL_NONE, SEL_MODE, SEL_BAUD, SEL_CTRL, SEL_TXD,
        SEL_STAT, SEL_RXD, SEL_FCTL, SEL_RCNT, SEL_PORT, SEL_LSTAT
    } reg_sel_e;

    // Internal flag indices
    localparam int FL_DR    = 0;
    localparam int FL_RDF   = 1;
    localparam int FL_BRK   = 2;
    localparam int FL_TDE   = 3;
    localparam int FL_TEND  = 4;
    localparam int NUM_FLAGS = 5;

    // Control register bits with a side effect
    localparam int CTRL_TE  = 5;
    localparam int CTRL_RIE = 6;
    localparam int CTRL_TIE = 7;

    // Bit position of each internal flag inside the status byte
    function automatic int stat_pos(input int idx);
        case (idx)
            FL_DR:   return 0;
            FL_RDF:  return 1;
            FL_BRK:  return 4;
            FL_TDE:  return 5;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/serial_regs_decode.sv
// Address decoder: maps a byte offset to a register select.
// Any offset not listed maps to SEL_NONE. Purely combinational.
module serial_regs_decode
    import serial_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Exact-match decode of the ten mapped offsets
    always_comb begin
        case (addr)
            ADDR_W'(OFF_MODE):  sel = SEL_MODE;
            ADDR_W'(OFF_BAUD):  sel = SEL_BAUD;
            ADDR_W'(OFF_CTRL):  sel = SEL_CTRL;
            ADDR_W'(OFF_TXD):   sel = SEL_TXD;
            ADDR_W'(OFF_STAT):  sel = SEL_STAT;
            ADDR_W'(OFF_RXD):   sel = SEL_RXD;
            ADDR_W'(OFF_FCTL):  sel = SEL_FCTL;
            ADDR_W'(OFF_RCNT):  sel = SEL_RCNT;
            ADDR_W'(OFF_PORT):  sel = SEL_PORT;
            ADDR_W'(OFF_LSTAT): sel = SEL_LSTAT;
            default:            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/serial_regs_cfg.sv
// Masked configuration register: stores wdata & MASK on a write.
// Assumes the caller qualifies the write strobe with the decode.
module serial_regs_cfg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Hold the register; load the masked data on a write
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= wdata & MASK;
    end

endmodule

// File: rtl/serial_regs_flags.sv
// Bank of sticky flags, each with its own set and clear request.
// A set request beats a clear request in the same cycle.
module serial_regs_flags #(
    parameter int            NF      = 5,
    parameter logic [NF-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    output logic [NF-1:0] flags_q
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        // One flag: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= RST_VAL[i];
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_regs_top.sv
// Control/status register bank of a FIFO serial controller.
// Reads return data one cycle after rd_en. A write wins over a read
// in the same cycle. Receive events are single-cycle pulses.
module serial_regs_top
    import serial_regs_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 5,
    parameter logic [DATA_W-1:0] MODE_MASK = 8'h7B,
    parameter logic [DATA_W-1:0] CTRL_MASK = 8'hFA,
    parameter logic [DATA_W-1:0] PORT_MASK = 8'hF3,
    parameter logic [DATA_W-1:0] BAUD_RST  = 8'hFF,
    parameter logic [DATA_W-1:0] CTRL_RST  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              rx_ready_evt,
    input  logic              rx_full_evt,
    input  logic              rx_break_evt,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [CNT_W-1:0]  rx_level,
    output logic              rx_pop,
    output logic [DATA_W-1:0] fifo_ctrl
);

    localparam logic [NUM_FLAGS-1:0] FLAG_RST =
        NUM_FLAGS'((1 << FL_TDE) | (1 << FL_TEND));
    localparam int PAD_W = DATA_W - CNT_W;

    reg_sel_e              sel;
    logic                  rd;
    logic                  we_mode, we_baud, we_ctrl, we_port, we_fctl;
    logic                  we_stat, we_txd, rd_stat;
    logic [DATA_W-1:0]     mode_q, baud_q, ctrl_q, port_q;
    logic [NUM_FLAGS-1:0]  set_vec, clr_vec, flags_q;
    logic [DATA_W-1:0]     stat_byte;
    logic                  irq_set, irq_clr;

    serial_regs_decode #(.ADDR_W(ADDR_W)) decode_i (.addr(addr), .sel(sel));

    // Access qualification: a write suppresses a simultaneous read
    always_comb begin
        rd      = rd_en & ~wr_en;
        we_mode = wr_en && sel == SEL_MODE;
        we_baud = wr_en && sel == SEL_BAUD;
        we_ctrl = wr_en && sel == SEL_CTRL;
        we_port = wr_en && sel == SEL_PORT;
        we_fctl = wr_en && sel == SEL_FCTL;
        we_stat = wr_en && sel == SEL_STAT;
        we_txd  = wr_en && sel == SEL_TXD;
        rd_stat = rd && sel == SEL_STAT;
        rx_pop  = rd && sel == SEL_RXD;
    end

    serial_regs_cfg #(.W(DATA_W), .MASK(MODE_MASK), .RST('0))
        mode_i (.clk(clk), .rst_n(rst_n), .we(we_mode), .wdata(wdata), .q(mode_q));
    serial_regs_cfg #(.W(DATA_W), .MASK('1), .RST(BAUD_RST))
        baud_i (.clk(clk), .rst_n(rst_n), .we(we_baud), .wdata(wdata), .q(baud_q));
    serial_regs_cfg #(.W(DATA_W), .MASK(CTRL_MASK), .RST(CTRL_RST))
        ctrl_i (.clk(clk), .rst_n(rst_n), .we(we_ctrl), .wdata(wdata), .q(ctrl_q));
    serial_regs_cfg #(.W(DATA_W), .MASK(PORT_MASK), .RST('0))
        port_i (.clk(clk), .rst_n(rst_n), .we(we_port), .wdata(wdata), .q(port_q));
    serial_regs_cfg #(.W(DATA_W), .MASK('1), .RST('0))
        fctl_i (.clk(clk), .rst_n(rst_n), .we(we_fctl), .wdata(wdata), .q(fifo_ctrl));

    // Flag set requests from receive events and transmit side effects
    always_comb begin
        set_vec          = '0;
        set_vec[FL_DR]   = rx_ready_evt;
        set_vec[FL_RDF]  = rx_full_evt;
        set_vec[FL_BRK]  = rx_break_evt;
        set_vec[FL_TDE]  = rd_stat && ctrl_q[CTRL_TE];
        set_vec[FL_TEND] = (rd_stat && ctrl_q[CTRL_TE]) || (we_ctrl && !wdata[CTRL_TE]);
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
        if (i == FL_TDE) begin : g_tde
            // Transmit-empty also clears on a transmit data write
            assign clr_vec[i] = (we_stat && !wdata[stat_pos(i)]) || we_txd;
        end else begin : g_other
            // Write-zero-to-clear from the status register
            assign clr_vec[i] = we_stat && !wdata[stat_pos(i)];
        end
    end

    serial_regs_flags #(.NF(NUM_FLAGS), .RST_VAL(FLAG_RST)) flags_i (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags_q(flags_q)
    );

    // Scatter the internal flags into their status byte positions
    always_comb begin
        stat_byte = '0;
        for (int i = 0; i < NUM_FLAGS; i++) stat_byte[stat_pos(i)] = flags_q[i];
    end

    // Receive interrupt request terms
    always_comb begin
        irq_set = rx_full_evt && ctrl_q[CTRL_RIE];
        irq_clr = (we_ctrl && !wdata[CTRL_RIE]) ||
                  (we_stat && (!wdata[stat_pos(FL_RDF)] || !wdata[stat_pos(FL_DR)]));
    end

    // Receive interrupt line: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_irq <= 1'b0;
        else if (irq_set) rx_irq <= 1'b1;
        else if (irq_clr) rx_irq <= 1'b0;
    end

    // Transmit interrupt line follows the enable bit of each control write
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_irq <= 1'b0;
        else if (we_ctrl) tx_irq <= wdata[CTRL_TIE];
    end

    // Transmit byte strobe, one cycle after the data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= we_txd;
            if (we_txd) tx_byte <= wdata;
        end
    end

    // Unmapped-offset error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (wr_en || rd_en) && sel == SEL_NONE;
    end

    // Registered read data mux, captured before any read side effect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel)
                SEL_MODE: rdata <= mode_q;
                SEL_BAUD: rdata <= baud_q;
                SEL_CTRL: rdata <= ctrl_q;
                SEL_STAT: rdata <= stat_byte;
                SEL_RXD:  rdata <= rx_data;
                SEL_FCTL: rdata <= fifo_ctrl;
                SEL_RCNT: rdata <= {{PAD_W{1'b0}}, rx_level};
                SEL_PORT: rdata <= port_q;
                default:  rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/serial_regs_chk.sv
// Assertion checker for serial_regs_top, attached with bind.
module serial_regs_chk
    import serial_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic                 err,
    input logic [DATA_W-1:0]    tx_byte,
    input logic                 tx_valid,
    input logic                 tx_irq,
    input logic                 rx_irq,
    input logic                 rx_full_evt,
    input logic                 rx_break_evt,
    input logic [DATA_W-1:0]    rx_data,
    input logic                 rx_pop,
    input logic [NUM_FLAGS-1:0] flags_q
);

    logic unmapped;
    always_comb begin
        unmapped = !(addr inside {ADDR_W'(OFF_MODE), ADDR_W'(OFF_BAUD), ADDR_W'(OFF_CTRL),
                                  ADDR_W'(OFF_TXD), ADDR_W'(OFF_STAT), ADDR_W'(OFF_RXD),
                                  ADDR_W'(OFF_FCTL), ADDR_W'(OFF_RCNT), ADDR_W'(OFF_PORT),
                                  ADDR_W'(OFF_LSTAT)});
    end

    // R7
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_TXD)) |=> (tx_valid && tx_byte == $past(wdata)));

    // R8
    tx_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CTRL)) |=> (tx_irq == $past(wdata[CTRL_TIE])));

    // R9
    rx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CTRL) && !wdata[CTRL_RIE] && !rx_full_evt) |=> !rx_irq);

    // R10
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && unmapped) |=> err);

    // R10
    mapped_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!((wr_en || rd_en) && unmapped)) |=> !err);

    // R11
    break_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break_evt |=> flags_q[FL_BRK]);

    // R12
    pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> (rdata == $past(rx_data)));

endmodule

bind serial_regs_top serial_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_full_evt(rx_full_evt),
    .rx_break_evt(rx_break_evt), .rx_data(rx_data), .rx_pop(rx_pop), .flags_q(flags_q)
);

// File: tb/serial_regs_top_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a behavioural model kept in bench variables.
module serial_regs_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, tx_byte, fifo_ctrl;
    logic       err, tx_valid, tx_irq, rx_irq, rx_pop;
    logic       rx_ready_evt = 1'b0, rx_full_evt = 1'b0, rx_break_evt = 1'b0;
    logic [7:0] rx_data = '0;
    logic [4:0] rx_level = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    logic [7:0] m_mode, m_baud, m_ctrl, m_port, m_fctl, m_stat;
    logic       m_txirq, m_rxirq;

    always #5 clk = ~clk;

    serial_regs_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .err(err), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_ready_evt(rx_ready_evt),
        .rx_full_evt(rx_full_evt), .rx_break_evt(rx_break_evt), .rx_data(rx_data),
        .rx_level(rx_level), .rx_pop(rx_pop), .fifo_ctrl(fifo_ctrl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic bit is_mapped(input logic [5:0] a);
        return a inside {6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24};
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00, 6'h04, 6'h08, 6'h18, 6'h20: return "R2";
            6'h10:                             return "R4";
            6'h14, 6'h1C, 6'h24, 6'h0C:        return "R12";
            default:                           return "R10";
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [5:0] a);
        case (a)
            6'h00:   return m_mode;
            6'h04:   return m_baud;
            6'h08:   return m_ctrl;
            6'h10:   return m_stat;
            6'h14:   return rx_data;
            6'h18:   return m_fctl;
            6'h1C:   return {3'b000, rx_level};
            6'h20:   return m_port;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 8'h00; m_baud = 8'hFF; m_ctrl = 8'h20; m_port = 8'h00;
        m_fctl = 8'h00; m_stat = 8'h60; m_txirq = 1'b0; m_rxirq = 1'b0;
    endtask

    // One bus cycle with optional receive events; updates the model and checks outputs
    task automatic acc(input bit w, input bit r, input logic [5:0] a, input logic [7:0] d,
                       input bit e_dr, input bit e_rdf, input bit e_brk, input string tag);
        logic [7:0] exp_rd, nstat;
        bit         do_rd, exp_err, pop_seen, irq_set, irq_clr;
        string      t;
        t = (tag == "") ? tag_of(a) : tag;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        rx_ready_evt = e_dr; rx_full_evt = e_rdf; rx_break_evt = e_brk;
        rx_data = 8'($urandom); rx_level = 5'($urandom);
        #1 pop_seen = rx_pop;
        do_rd   = r && !w;
        exp_rd  = model_read(a);
        exp_err = (w || r) && !is_mapped(a);
        // Flag update: clears first, then sets, so sets win
        nstat = m_stat;
        if (w && a == 6'h10) nstat = nstat & (d | 8'h8C);
        if (w && a == 6'h0C) nstat[5] = 1'b0;
        if (w && a == 6'h08 && !d[5]) nstat[6] = 1'b1;
        if (do_rd && a == 6'h10 && m_ctrl[5]) nstat = nstat | 8'h60;
        if (e_dr)  nstat[0] = 1'b1;
        if (e_rdf) nstat[1] = 1'b1;
        if (e_brk) nstat[4] = 1'b1;
        irq_set = e_rdf && m_ctrl[6];
        irq_clr = (w && a == 6'h08 && !d[6]) || (w && a == 6'h10 && (!d[1] || !d[0]));
        if (irq_set)      m_rxirq = 1'b1;
        else if (irq_clr) m_rxirq = 1'b0;
        if (w && a == 6'h08) m_txirq = d[7];
        if (w) begin
            case (a)
                6'h00: m_mode = d & 8'h7B;
                6'h04: m_baud = d;
                6'h08: m_ctrl = d & 8'hFA;
                6'h18: m_fctl = d;
                6'h20: m_port = d & 8'hF3;
                default: ;
            endcase
        end
        m_stat = nstat;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        rx_ready_evt = 1'b0; rx_full_evt = 1'b0; rx_break_evt = 1'b0;
        if (do_rd) check(t, rdata, exp_rd);
        check("R10 err", {7'd0, err}, {7'd0, exp_err});
        check("R7 tx_valid", {7'd0, tx_valid}, {7'd0, w && a == 6'h0C});
        if (w && a == 6'h0C) check("R7 tx_byte", tx_byte, d);
        check("R8 tx_irq", {7'd0, tx_irq}, {7'd0, m_txirq});
        check("R9 rx_irq", {7'd0, rx_irq}, {7'd0, m_rxirq});
        check("R12 rx_pop", {7'd0, pop_seen}, {7'd0, do_rd && a == 6'h14});
        check("R2 fifo_ctrl", fifo_ctrl, m_fctl);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] alist [13];
        alist = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24,
                  6'h02, 6'h28, 6'h3C};
        void'($urandom(32'h00C0FFEE));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check("R1 tx_irq", {7'd0, tx_irq}, 8'd0);
        check("R1 rx_irq", {7'd0, rx_irq}, 8'd0);
        foreach (alist[i]) if (i < 10 && alist[i] != 6'h14 && alist[i] != 6'h1C)
            acc(0, 1, alist[i], 8'h00, 0, 0, 0, "R1");
        // R2: masks
        acc(1, 0, 6'h00, 8'hFF, 0, 0, 0, ""); acc(0, 1, 6'h00, 0, 0, 0, 0, "R2");
        acc(1, 0, 6'h08, 8'hFF, 0, 0, 0, ""); acc(0, 1, 6'h08, 0, 0, 0, 0, "R2");
        acc(1, 0, 6'h20, 8'hFF, 0, 0, 0, ""); acc(0, 1, 6'h20, 0, 0, 0, 0, "R2");
        acc(1, 0, 6'h04, 8'h3C, 0, 0, 0, ""); acc(0, 1, 6'h04, 0, 0, 0, 0, "R2");
        acc(1, 0, 6'h18, 8'hC2, 0, 0, 0, ""); acc(0, 1, 6'h18, 0, 0, 0, 0, "R2");
        // R3: event pulses set their status bits
        acc(0, 0, 6'h00, 0, 1, 1, 1, "");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R3");
        // R9: rx_full with receive interrupt enabled raises rx_irq; status clear drops it
        acc(0, 0, 6'h00, 0, 0, 1, 0, "R9");
        acc(1, 0, 6'h10, 8'hFE, 0, 0, 0, "R9");
        // R4: write-one keeps, write-zero clears
        acc(1, 0, 6'h10, 8'hEF, 0, 0, 0, ""); acc(0, 1, 6'h10, 0, 0, 0, 0, "R4");
        // R5: read returns old value, then sets transmit flags
        acc(1, 0, 6'h10, 8'h00, 0, 0, 0, "");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R5");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R5");
        // R6: control write with transmit enable 0 sets transmit-end; read has no side effect
        acc(1, 0, 6'h10, 8'h00, 0, 0, 0, "");
        acc(1, 0, 6'h08, 8'h40, 0, 0, 0, "");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R6");
        // R7: transmit write clears transmit-empty
        acc(1, 0, 6'h08, 8'hA0, 0, 0, 0, "");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R7");
        acc(1, 0, 6'h0C, 8'hA5, 0, 0, 0, "R7");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R7");
        // R11: set event and clear in the same cycle
        acc(1, 0, 6'h08, 8'h60, 0, 0, 0, "");
        acc(1, 0, 6'h10, 8'h00, 1, 1, 1, "R11");
        acc(0, 1, 6'h10, 0, 0, 0, 0, "R11");
        // R10: unmapped accesses change nothing
        acc(1, 0, 6'h02, 8'h00, 0, 0, 0, "R10");
        acc(0, 1, 6'h3C, 0, 0, 0, 0, "R10");
        acc(0, 1, 6'h08, 0, 0, 0, 0, "R10");
        // R12: writes to read-only offsets, simultaneous write and read
        acc(1, 0, 6'h24, 8'hFF, 0, 0, 0, "R12");
        acc(1, 1, 6'h04, 8'h5A, 0, 0, 0, "R12");
        acc(0, 1, 6'h04, 0, 0, 0, 0, "R12");
        acc(0, 1, 6'h1C, 0, 0, 0, 0, "R12");
        acc(0, 1, 6'h14, 0, 0, 0, 0, "R12");
        // Random traffic
        for (int k = 0; k < 600; k++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [5:0]  a  = alist[$urandom_range(0, 12)];
            acc(op < 4, op >= 4 && op < 9, a, 8'($urandom),
                $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                $urandom_range(0, 7) == 0, "");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule